// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned operands by counting. When a start strobe is seen while the block is idle, it captures the multiplicand and the multiplier and clears its product accumulator. On each following clock it adds the multiplicand into the accumulator and counts the captured multiplier down by one. It keeps doing this until the count reaches zero. A two-state controller steers a datapath that holds three registers, two adders and a zero detector. The count-down step uses a single-width adder fed with an all-ones word. The accumulation uses a separate double-width adder.

A user pulses start for one cycle with both operand buses valid, then waits for done to return high. The product output then holds the result until the next accepted start. The run time depends on the data: a multiplier of value B keeps the block busy for B+1 cycles after the start cycle. The block does not accept a new request while it is busy.

Top module: `repadd_mul`

## Requirements
- R1: While rstN is low, and after it is released with no start, product reads 0 and done reads 1. The reset is asynchronous.
- R2: If start is 1 on an idle clock edge, the operands are captured at that edge. After that edge, product reads 0 and done reads 0.
- R3: While idle with start at 0, done stays 1 and product holds its value, whatever the operand buses carry.
- R4: On each busy clock edge where the remaining count is nonzero, product grows by exactly the captured multiplicand and the count drops by one.
- R5: The block returns to idle on the first busy edge that finds the count at zero. done therefore rises B+1 edges after the start edge, and product then equals A*B.
- R6: A multiplier of 0 finishes one edge after the start edge with product 0. A multiplicand of 0 gives product 0 after B+1 edges.
- R7: While the block is busy, start and both operand buses are ignored. The result and the latency depend only on the operands captured at the accepted start.
- R8: The accumulator never carries out of its 16 bits. The largest pair, 255*255, yields 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while idle |
| mcandIn | input | 8 | Multiplicand operand A |
| mplierIn | input | 8 | Multiplier operand B, which is also the loop count |
| product | output | 16 | Accumulated product |
| done | output | 1 | High while idle, which includes after a finished run |

## Verification
The assertions watch the step-by-step rules on every cycle:
- each add-and-count step adds the multiplicand and lowers the count by one;
- a load clears the accumulator and drops done;
- no add is issued once the count is zero;
- a zero count always leads to idle on the next edge;
- the accumulator never carries out.

Only the bench's scenarios can show the end-to-end results:
- the final product for the corner operands 0, 1 and 255 and for random pairs;
- the exact B+1 latency;
- that a start or operand change during a run leaves the result untouched;
- that the output holds while idle.

// File: rtl/repadd_pkg.sv
`timescale 1ns/1ps
package repadd_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadOps;  // capture operands, clear accumulator
    logic addDec;   // accumulate multiplicand, count down
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;
endpackage

// File: rtl/repadd_ctrl.sv
`timescale 1ns/1ps
module repadd_ctrl
  import repadd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output logic         done
);

  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD          = stateQ;
    strobes.loadOps = 1'b0;
    strobes.addDec  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.loadOps = 1'b1;
          stateD          = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cntZero) begin
          stateD = ST_IDLE;
        end else begin
          strobes.addDec = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign done = (stateQ == ST_IDLE);

  AST_LOAD_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOps |=> !done); // R2
  AST_NO_ADD_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cntZero |-> !strobes.addDec); // R5
  AST_ZERO_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!done && cntZero) |=> done); // R5
  AST_BUSY_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !cntZero) |=> !done); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R3

endmodule

// File: rtl/repadd_dpath.sv
`timescale 1ns/1ps
module repadd_dpath
  import repadd_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [OP_W-1:0]     mcandIn,
  input  logic [OP_W-1:0]     mplierIn,
  output logic [2*OP_W-1:0]   accOut,
  output logic                cntZero
);
  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0]   mcandQ, mcandD;
  logic [OP_W-1:0]   countQ, countD;
  logic [PROD_W-1:0] accQ, accD;

  // Double-width adder with a spare carry bit
  logic [PROD_W:0]   sumWide;
  logic [PROD_W-1:0] accSum;
  // Single-width count-down: add all ones
  logic [OP_W-1:0]   countDec;

  assign sumWide  = {1'b0, accQ} + {{(OP_W+1){1'b0}}, mcandQ};
  assign accSum   = sumWide[PROD_W-1:0];
  assign countDec = countQ + {OP_W{1'b1}};
  assign cntZero  = ~|countQ;

  // Input selection for each register: hold, bus load, or adder result
  always_comb begin
    mcandD = mcandQ;
    countD = countQ;
    accD   = accQ;
    if (strobes.loadOps) begin
      mcandD = mcandIn;
      countD = mplierIn;
      accD   = '0;
    end else if (strobes.addDec) begin
      countD = countDec;
      accD   = accSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ <= '0;
      countQ <= '0;
      accQ   <= '0;
    end else begin
      mcandQ <= mcandD;
      countQ <= countD;
      accQ   <= accD;
    end
  end

  assign accOut = accQ;

  AST_LOAD_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOps |=> (accQ == '0)); // R2
  AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addDec |=> (accQ == $past(accQ) + {{OP_W{1'b0}}, $past(mcandQ)})); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addDec |=> (countQ == $past(countQ) - 1'b1)); // R4
  AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadOps && !strobes.addDec) |=> ($stable(accQ) && $stable(countQ) && $stable(mcandQ))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addDec |-> !sumWide[PROD_W]); // R8

endmodule

// File: rtl/repadd_mul.sv
`timescale 1ns/1ps
module repadd_mul
  import repadd_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   mcandIn,
  input  logic [OP_W-1:0]   mplierIn,
  output logic [2*OP_W-1:0] product,
  output logic              done
);

  ctrlStrobes_t strobes;
  logic         cntZero;

  repadd_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cntZero (cntZero),
    .strobes (strobes),
    .done    (done)
  );

  repadd_dpath #(.OP_W(OP_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mcandIn  (mcandIn),
    .mplierIn (mplierIn),
    .accOut   (product),
    .cntZero  (cntZero)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (done && product == '0)); // R1

endmodule

// File: tb/test_repadd_mul.sv
`timescale 1ns/1ps
module test_repadd_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mcandIn = '0;
  logic [7:0]  mplierIn = '0;
  logic [15:0] product;
  logic        done;

  int nVec = 0;
  int nBad = 0;
  int cycles = 0;

  // Behavioural reference state
  bit          mBusy;
  int          mCnt, mAcc, mMc;
  bit          cmpOn = 1'b0;

  always #2 clk = ~clk;

  repadd_mul i_repadd_mul (
    .clk(clk), .rstN(rstN), .start(start),
    .mcandIn(mcandIn), .mplierIn(mplierIn),
    .product(product), .done(done)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mCnt = 0; mAcc = 0; mMc = 0;
    end else if (!mBusy) begin
      if (start) begin
        mBusy = 1; mMc = int'(mcandIn); mCnt = int'(mplierIn); mAcc = 0;
      end
    end else if (mCnt == 0) begin
      mBusy = 0;
    end else begin
      mAcc = mAcc + mMc; mCnt = mCnt - 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    cycles++;
    if (cmpOn && rstN) begin
      check(mBusy ? "R4 done" : "R3 done", int'(done), mBusy ? 0 : 1);
      check(mBusy ? "R4 product" : "R3 product", int'(product), mAcc);
    end
  end

  // Watchdog
  initial begin
    wait (cycles > 150000);
    nBad++;
    $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  task automatic runMul(input int a, input int b, input bit noise);
    int n;
    @(negedge clk);
    start = 1'b1; mcandIn = 8'(a); mplierIn = 8'(b);
    @(negedge clk);
    start = 1'b0; mcandIn = 8'(~a); mplierIn = 8'(b + 3);
    check("R2 done low after start", int'(done), 0);
    check("R2 product cleared", int'(product), 0);
    n = 0;
    while (!done && n < 300) begin
      if (noise && n < b) begin
        start = 1'b1; mcandIn = 8'($urandom); mplierIn = 8'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (noise) check("R7 latency unaffected by busy start", n, b + 1);
    else if (b == 0) check("R6 zero multiplier latency", n, 1);
    else check("R5 latency", n, b + 1);
    if (a == 0 || b == 0) check("R6 zero product", int'(product), 0);
    else if (a == 255 && b == 255) check("R8 full-scale product", int'(product), 65025);
    else if (noise) check("R7 product unaffected", int'(product), a * b);
    else check("R5 product", int'(product), a * b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 1);
    check("R1 reset product", int'(product), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", int'(done), 1);

    runMul(0, 0, 0);
    runMul(9, 0, 0);
    runMul(0, 12, 0);
    runMul(1, 1, 0);
    runMul(255, 1, 0);
    runMul(1, 255, 0);
    runMul(255, 255, 0);
    runMul(13, 7, 0);
    runMul(200, 40, 1);

    // Idle hold with changing buses
    for (int k = 0; k < 5; k++) begin
      mcandIn = 8'($urandom); mplierIn = 8'($urandom);
      @(negedge clk);
      check("R3 idle hold", int'(product), 8000);
    end

    for (int k = 0; k < 12; k++) begin
      int a, b;
      a = int'($urandom_range(0, 255));
      b = int'($urandom_range(0, 255));
      runMul(a, b, k[0]);
    end

    // Asynchronous reset in the middle of a run
    @(negedge clk);
    start = 1'b1; mcandIn = 8'd5; mplierIn = 8'd50;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    check("R1 async reset done", int'(done), 1);
    check("R1 async reset product", int'(product), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule